// File: doc/BRIEF.md
# Page-Mode Flash Read Controller

This controller sits on the host side of an asynchronous parallel NOR flash that supports fast page reads. Read requests arrive on a valid/ready handshake. Each request carries a byte address and a byte/word mode flag. The controller drives chip enable, output enable, the address pins and the byte-select pin. It then waits a programmable number of clock cycles and captures the data bus, returning the result with a one-cycle valid strobe.

A page is the set of locations that share address bits [21:3]. Within a page, bits [2:1] pick one of 4 words in word mode. Bits [2:0] pick one of 8 bytes in byte mode. The first read of a page waits the long random-access count. A read that arrives back-to-back, in the same mode and inside the page that is still open, waits only the short page-access count. The open page is dropped in three cases: chip enable is released after a response with no request pending, a reset occurs, or the mode changes.

The control is one state machine with three states. IDLE has chip enable released and no open page. ACCESS has chip enable and output enable both asserted while the wait timer runs. OPEN has chip enable held with output enable released, in the cycle after capture. The transitions are:
- IDLE→ACCESS when a request is accepted.
- ACCESS→OPEN when the timer expires.
- OPEN→ACCESS when a request arrives.
- OPEN→IDLE when no request arrives.

Top module: `flash_page_rd`

## Requirements
- R1: After reset, chip enable (`fl_ce_n`) and output enable (`fl_oe_n`) are high, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A read accepted from IDLE produces `rsp_valid` exactly `cfg_rand_wait` clock edges after the accepting edge.
- R3: A read accepted in OPEN in the same mode, with `req_addr[21:3]` equal to that of the previous read, produces `rsp_valid` `cfg_page_wait` edges after acceptance.
- R4: A read accepted in OPEN whose `req_addr[21:3]` differs from the previous read uses the `cfg_rand_wait` latency.
- R5: A read whose `req_byte_mode` differs from the previous read uses the `cfg_rand_wait` latency, even within the same page.
- R6: In OPEN with no request pending, the block returns to IDLE with `fl_ce_n` high, and the next read uses the `cfg_rand_wait` latency.
- R7: `fl_oe_n` is low only while `fl_ce_n` is low and a read is waiting for data.
- R8: `rsp_valid` is never high for two cycles in a row. `rsp_data` is the data bus sampled on the cycle the wait expires.
- R9: In word mode (`req_byte_mode`=0), `fl_addr` = `req_addr[21:1]`, `fl_alsb` = 0 and `rsp_data` is the full 16-bit bus. In byte mode, `fl_alsb` = `req_addr[0]`, `fl_byte_n` = 0, and `rsp_data` = {8'h00, bus[7:0]}.
- R10: A wait count of 0 behaves as 1.
- R11: `req_ready` is 0 while a read is in progress, so no request is accepted during ACCESS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 22 | Byte address; bits [21:3] select the page |
| req_byte_mode | input | 1 | 1 = byte read, 0 = word read |
| cfg_rand_wait | input | 6 | Cycles for a first (random) access |
| cfg_page_wait | input | 6 | Cycles for an in-page access |
| rsp_valid | output | 1 | One-cycle strobe with read data |
| rsp_data | output | 16 | Read data |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_byte_n | output | 1 | Low selects byte-wide bus |
| fl_addr | output | 21 | Flash address pins, word granular |
| fl_alsb | output | 1 | Lowest byte-address pin, used in byte mode |
| fl_dq | input | 16 | Flash data bus |

## Verification
The bench aims at the page boundary. It reads the last word of one page and then the first word of the next; a design that keyed the page on too few address bits would give the second read the short latency. It changes mode inside an open page and inserts idle gaps after a response, so a tracker that ignored mode or failed to invalidate on chip-enable release would show the page latency where the long one is due. Zero wait counts are tested as well: a design without the clamp would hang or respond on the wrong edge. The flash model returns a poison value whenever output enable is high, so a capture outside the gated window shows up as wrong data.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_OPEN   = 2'd2
    } rd_state_t;
endpackage

// File: rtl/flash_page_tracker.sv
module flash_page_tracker #(
    parameter int KEY_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [KEY_W-1:0] key,
    input  logic             byte_mode,
    output logic             hit
);
    logic             open_q;
    logic [KEY_W-1:0] key_q;
    logic             mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            key_q  <= '0;
            mode_q <= 1'b0;
        end else if (load) begin
            open_q <= 1'b1;
            key_q  <= key;
            mode_q <= byte_mode;
        end else if (clear) begin
            open_q <= 1'b0;
        end
    end

    assign hit = open_q && (key_q == key) && (mode_q == byte_mode);

    // R6: a dropped page cannot produce a hit on the next cycle
    p_clear_drops_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> !hit);
endmodule

// File: rtl/flash_wait_timer.sv
module flash_wait_timer #(
    parameter int WAIT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expire
);
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] start_val;

    assign start_val = (load_val == '0) ? WAIT_W'(1) : load_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= start_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == WAIT_W'(1));

    // R10: a loaded count is never zero, so the timer always expires
    p_load_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q != '0));
endmodule

// File: rtl/flash_page_rd.sv
module flash_page_rd
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int DATA_W   = 16,
    parameter int WAIT_W   = 6,
    parameter int PAGE_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_byte_mode,
    input  logic [WAIT_W-1:0] cfg_rand_wait,
    input  logic [WAIT_W-1:0] cfg_page_wait,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              fl_ce_n,
    output logic              fl_oe_n,
    output logic              fl_byte_n,
    output logic [ADDR_W-2:0] fl_addr,
    output logic              fl_alsb,
    input  logic [DATA_W-1:0] fl_dq
);
    localparam int KEY_W = ADDR_W - PAGE_LSB;

    rd_state_t         st_q, st_d;
    logic              accept;
    logic              page_hit;
    logic              page_clear;
    logic              expire;
    logic [WAIT_W-1:0] wait_sel;
    logic [ADDR_W-1:0] addr_q;
    logic              mode_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;

    assign accept     = req_valid && req_ready;
    assign page_clear = (st_q == ST_OPEN) && !req_valid;
    assign wait_sel   = page_hit ? cfg_page_wait : cfg_rand_wait;

    flash_page_tracker #(.KEY_W(KEY_W)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .clear     (page_clear),
        .key       (req_addr[ADDR_W-1:PAGE_LSB]),
        .byte_mode (req_byte_mode),
        .hit       (page_hit)
    );

    flash_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_sel),
        .expire   (expire)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_d;
    end

    // next state and pin outputs
    always_comb begin
        st_d      = st_q;
        fl_ce_n   = 1'b0;
        fl_oe_n   = 1'b1;
        req_ready = 1'b1;
        unique case (st_q)
            ST_IDLE: begin
                fl_ce_n = 1'b1;
                if (req_valid) st_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                fl_oe_n   = 1'b0;
                req_ready = 1'b0;
                if (expire) st_d = ST_OPEN;
            end
            ST_OPEN: begin
                st_d = req_valid ? ST_ACCESS : ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // request capture and response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            mode_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
                mode_q <= req_byte_mode;
            end
            rsp_valid_q <= (st_q == ST_ACCESS) && expire;
            if ((st_q == ST_ACCESS) && expire)
                rsp_data_q <= mode_q ? {{(DATA_W-8){1'b0}}, fl_dq[7:0]} : fl_dq;
        end
    end

    assign fl_addr   = addr_q[ADDR_W-1:1];
    assign fl_alsb   = mode_q ? addr_q[0] : 1'b0;
    assign fl_byte_n = !mode_q;
    assign rsp_valid = rsp_valid_q;
    assign rsp_data  = rsp_data_q;

    // R7: data output is only enabled on a selected device
    p_oe_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> !fl_ce_n);
    // R8: response strobe lasts a single cycle
    p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R11: no request is taken while the bus is being read
    p_no_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> fl_oe_n);
    // R6: a response with nothing pending releases chip enable
    p_ce_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !req_valid) |=> fl_ce_n);
endmodule

// File: tb/flash_page_rd_test.sv
module flash_page_rd_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic        req_byte_mode = 1'b0;
    logic [5:0]  cfg_rand_wait = 6'd5;
    logic [5:0]  cfg_page_wait = 6'd2;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic        fl_ce_n, fl_oe_n, fl_byte_n, fl_alsb;
    logic [20:0] fl_addr;
    logic [15:0] fl_dq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int oe_bad = 0;
    int rdy_bad = 0;
    int strobe_bad = 0;
    logic prev_rsp = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    flash_page_rd uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_byte_mode(req_byte_mode),
        .cfg_rand_wait(cfg_rand_wait), .cfg_page_wait(cfg_page_wait),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fl_ce_n(fl_ce_n),
        .fl_oe_n(fl_oe_n), .fl_byte_n(fl_byte_n), .fl_addr(fl_addr),
        .fl_alsb(fl_alsb), .fl_dq(fl_dq)
    );

    function automatic logic [15:0] mem_word(logic [20:0] a, logic lsb);
        return {a[7:0] ^ 8'hA5, {a[6:0], lsb} ^ 8'h3C};
    endfunction

    // flash model: poison value unless selected and output enabled
    assign fl_dq = (!fl_ce_n && !fl_oe_n) ? mem_word(fl_addr, fl_alsb) : 16'hDEAD;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_oe_n && fl_ce_n) oe_bad++;
            if (req_ready && !fl_oe_n) rdy_bad++;
            if (rsp_valid && prev_rsp) strobe_bad++;
            prev_rsp <= rsp_valid;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_read(logic [21:0] a, logic bm, int exp_lat, string req);
        int lat = 0;
        logic [15:0] w;
        req_addr      = a;
        req_byte_mode = bm;
        req_valid     = 1'b1;
        while (!req_ready) begin
            @(posedge clk); @(negedge clk);
        end
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check({req, " pins addr"}, {11'd0, fl_addr}, {11'd0, a[21:1]});
        check({req, " pins lsb/byte_n"}, {fl_alsb, fl_byte_n}, {bm ? a[0] : 1'b0, !bm});
        while (!rsp_valid) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
        check({req, " latency"}, lat, exp_lat);
        w = mem_word(a[21:1], bm ? a[0] : 1'b0);
        check({req, " data R9"}, rsp_data, bm ? {8'h00, w[7:0]} : w);
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset pins", {fl_ce_n, fl_oe_n, req_ready, rsp_valid}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_first_and_in_page;
        do_read(22'h000100, 1'b0, 5, "R2 first access");
        do_read(22'h000102, 1'b0, 2, "R3 in-page");
        do_read(22'h000106, 1'b0, 2, "R3 in-page last word");
    endtask

    task automatic t_page_cross;
        do_read(22'h000108, 1'b0, 5, "R4 next page");
        do_read(22'h00010A, 1'b0, 2, "R3 new page hit");
        do_read(22'h040108, 1'b0, 5, "R4 high bits differ");
    endtask

    task automatic t_mode_switch;
        do_read(22'h04010B, 1'b1, 5, "R5 word to byte");
        do_read(22'h04010C, 1'b1, 2, "R9 byte even");
        do_read(22'h04010D, 1'b1, 2, "R9 byte odd");
        do_read(22'h04010E, 1'b0, 5, "R5 byte to word");
    endtask

    task automatic t_idle_close;
        idle(2);
        check("R6 ce released", fl_ce_n, 1'b1);
        do_read(22'h04010E, 1'b0, 5, "R6 reopen same page");
    endtask

    task automatic t_zero_wait;
        cfg_page_wait = 6'd0;
        idle(2);
        do_read(22'h000200, 1'b0, 5, "R2 before zero wait");
        do_read(22'h000202, 1'b0, 1, "R10 page wait zero");
        cfg_rand_wait = 6'd0;
        idle(2);
        do_read(22'h000300, 1'b0, 1, "R10 rand wait zero");
        idle(2);
    endtask

    task automatic t_monitors;
        check("R7 oe without ce", oe_bad, 0);
        check("R11 ready while reading", rdy_bad, 0);
        check("R8 strobe width", strobe_bad, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_and_in_page();
        t_page_cross();
        t_mode_switch();
        t_idle_close();
        t_zero_wait();
        t_monitors();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule